// File: doc/BRIEF.md
# Multichannel Audio Block Framer

The framer builds the payload of outgoing isochronous packets for a multichannel audio stream that carries no CIP header. A producer hands it one data block at a time: all channel samples side by side, under a valid/ready handshake. The framer latches the block and emits it as a run of quadlets, one per clock cycle, in channel order. Each quadlet pairs an 8-bit ancillary byte with a 24-bit PCM sample, and its bytes are placed in little-endian order.

The ancillary byte carries continuity information. Which counter it carries depends on the channel's position in the block. Some positions count data blocks. Some count groups of 256 blocks. Some count blocks in packet-sized steps. The remaining positions carry zero.

Every packet holds exactly `BLK_PER_PKT` blocks and is marked with start and end flags. The 2-bit packet tag steps through 0, 1, 2, 3 on a block-count interval. A rate-select input picks that interval.

Top module: `aud_block_framer`

## Requirements
- R1: A synchronous active-high reset leaves in_ready at 1, out_valid, out_sop and out_eop at 0, and out_tag at 0. The first block after reset carries zero in every counter-bearing ancillary byte.
- R2: A block is taken on a clock edge where in_valid and in_ready are both 1. From the next cycle, out_valid stays 1 for NCH consecutive cycles, one quadlet per channel, channels 1 to NCH in order. in_ready is 0 during those cycles, except on the last quadlet, so blocks can follow back to back.
- R3: Channel k (1-based) takes its sample from in_pcm[(k-1)*24 +: 24]. Call that sample S and its ancillary byte A. The quadlet is out_data = {A, S[7:0], S[15:8], S[23:16]}.
- R4: Channels 2 and 18 carry the number of blocks emitted since reset, modulo 256.
- R5: Channels 3, 4, 5, 11, 12 and 13 carry floor(blocks since reset / 256) modulo 8, with the upper five bits of the byte zero.
- R6: Channels 7, 8, 15 and 16 carry (packets completed since reset × BLK_PER_PKT) modulo 256. This value is constant within a packet.
- R7: Channels 1, 6, 9, 10, 14 and 17 carry an ancillary byte of 0.
- R8: out_sop is 1 only on the first quadlet of the first block of a packet. out_eop is 1 only on the last quadlet of block number BLK_PER_PKT of that packet. Every packet holds exactly BLK_PER_PKT blocks.
- R9: out_tag is constant within a packet and equals floor(blocks emitted before the packet / interval) modulo 4. The interval is 256 blocks when rate_sel is 0 (44.1/48 kHz) and 96 blocks when rate_sel is 1 (88.2 kHz). The tag therefore runs 0, 1, 2, 3, 0 and so on.
- R10: The sample inputs and in_valid have no effect while in_ready is 0. A block's quadlets carry the samples present at its accepting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rate_sel | input | 1 | Tag interval select: 0 for 256 blocks, 1 for 96 blocks |
| in_valid | input | 1 | A block of samples is offered |
| in_ready | output | 1 | The framer takes the offered block on this edge |
| in_pcm | input | NCH*24 | Samples; channel k occupies bits (k-1)*24 upward |
| out_valid | output | 1 | out_data holds a payload quadlet |
| out_data | output | 32 | Quadlet with the ancillary byte and the byte-swapped sample |
| out_sop | output | 1 | First quadlet of a packet |
| out_eop | output | 1 | Last quadlet of a packet |
| out_tag | output | 2 | Tag of the current packet |

## Verification
On every cycle, the assertions check several local properties:
- zero-position channels carry a zero ancillary byte;
- the 256-block counter never leaves its three-bit range;
- start and end markers never coincide;
- an accepted block always produces output on the next cycle;
- the tag holds within a packet and only ever steps by one.

The actual counter values need the bench's scenarios. These are the per-position values, the wrap of the block counter at 256, the wrap of the slow counter after 2048 blocks, and the full tag rotation at both intervals. The bench also compares byte order against held samples, and shows that samples changing while the framer is busy do not leak into the output.

// File: rtl/aud_block_framer.sv
module aud_block_framer #(
  parameter int NCH         = 18,
  parameter int BLK_PER_PKT = 8,
  parameter int IVL_STD     = 256,
  parameter int IVL_DBL     = 96
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rate_sel,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [NCH*24-1:0] in_pcm,
  output logic             out_valid,
  output logic [31:0]      out_data,
  output logic             out_sop,
  output logic             out_eop,
  output logic [1:0]       out_tag
);

  localparam int CH_W  = (NCH > 1) ? $clog2(NCH) : 1;
  localparam int BP_W  = $clog2(BLK_PER_PKT + 1);
  localparam int IVL_MAX = (IVL_STD > IVL_DBL) ? IVL_STD : IVL_DBL;
  localparam int IVL_W = $clog2(IVL_MAX + 1);

  localparam logic [1:0] K_NONE = 2'd0;
  localparam logic [1:0] K_BLK  = 2'd1;
  localparam logic [1:0] K_SLOW = 2'd2;
  localparam logic [1:0] K_PKT  = 2'd3;

  function automatic logic [1:0] kind_of(input int pos);
    case (pos)
      2, 18:                 kind_of = K_BLK;
      3, 4, 5, 11, 12, 13:   kind_of = K_SLOW;
      7, 8, 15, 16:          kind_of = K_PKT;
      default:               kind_of = K_NONE;
    endcase
  endfunction

  logic              busy;
  logic [CH_W-1:0]   ch;
  logic [NCH*24-1:0] pcm_buf;
  logic [7:0]        blk_cnt;
  logic [2:0]        slow_cnt;
  logic [7:0]        pkt_cnt;
  logic [BP_W-1:0]   bip;
  logic [IVL_W-1:0]  tag_cnt;
  logic [1:0]        tag_run;
  logic [1:0]        pkt_tag;

  logic              last, accept, pkt_last, tag_wrap;
  logic [IVL_W-1:0]  ivl_m1;
  logic [1:0]        tag_nxt;
  logic [23:0]       cur_pcm;
  logic [1:0]        cur_kind;
  logic [7:0]        anc;

  assign last     = busy && (ch == CH_W'(NCH - 1));
  assign in_ready = !busy || last;
  assign accept   = in_valid && in_ready;
  assign pkt_last = (bip == BP_W'(BLK_PER_PKT - 1));
  assign ivl_m1   = rate_sel ? IVL_W'(IVL_DBL - 1) : IVL_W'(IVL_STD - 1);
  assign tag_wrap = (tag_cnt >= ivl_m1);
  assign tag_nxt  = tag_wrap ? tag_run + 2'd1 : tag_run;

  assign cur_pcm  = pcm_buf[int'(ch)*24 +: 24];
  assign cur_kind = kind_of(int'(ch) + 1);

  always_comb begin
    case (cur_kind)
      K_BLK:   anc = blk_cnt;
      K_SLOW:  anc = {5'd0, slow_cnt};
      K_PKT:   anc = pkt_cnt;
      default: anc = 8'd0;
    endcase
  end

  assign out_valid = busy;
  assign out_data  = {anc, cur_pcm[7:0], cur_pcm[15:8], cur_pcm[23:16]};
  assign out_sop   = busy && (ch == '0) && (bip == '0);
  assign out_eop   = last && pkt_last;
  assign out_tag   = pkt_tag;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      ch   <= '0;
    end else if (accept) begin
      busy    <= 1'b1;
      ch      <= '0;
      pcm_buf <= in_pcm;
    end else if (last) begin
      busy <= 1'b0;
      ch   <= '0;
    end else if (busy) begin
      ch <= ch + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      blk_cnt  <= '0;
      slow_cnt <= '0;
      pkt_cnt  <= '0;
      bip      <= '0;
      tag_cnt  <= '0;
      tag_run  <= '0;
      pkt_tag  <= '0;
    end else if (last) begin
      blk_cnt <= blk_cnt + 8'd1;
      if (blk_cnt == 8'hff) slow_cnt <= slow_cnt + 3'd1;
      tag_cnt <= tag_wrap ? '0 : tag_cnt + 1'b1;
      tag_run <= tag_nxt;
      if (pkt_last) begin
        bip     <= '0;
        pkt_cnt <= pkt_cnt + 8'(BLK_PER_PKT);
        pkt_tag <= tag_nxt;
      end else begin
        bip <= bip + 1'b1;
      end
    end
  end

  // R2
  p_accept_emits_r2: assert property (@(posedge clk) disable iff (rst)
    $past(in_valid && in_ready) |-> out_valid);
  // R7
  p_idle_pos_zero_r7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && cur_kind == K_NONE) |-> (out_data[31:24] == 8'd0));
  // R5
  p_slow_range_r5: assert property (@(posedge clk) disable iff (rst)
    (out_valid && cur_kind == K_SLOW) |-> (out_data[31:27] == 5'd0));
  // R8
  p_sop_eop_excl_r8: assert property (@(posedge clk) disable iff (rst)
    out_sop |-> (out_valid && !out_eop));
  // R9
  p_tag_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_sop) |-> $stable(out_tag));
  // R9
  p_tag_step_r9: assert property (@(posedge clk) disable iff (rst)
    !$stable(out_tag) |-> (out_tag == $past(out_tag) + 2'd1));

endmodule

// File: tb/test_aud_block_framer.sv
module test_aud_block_framer;
  localparam int NCH = 18;
  localparam int BPP = 8;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              rate_sel = 1'b0;
  logic              in_valid = 1'b0;
  logic              in_ready;
  logic [NCH*24-1:0] in_pcm = '0;
  logic              out_valid;
  logic [31:0]       out_data;
  logic              out_sop, out_eop;
  logic [1:0]        out_tag;

  aud_block_framer #(.NCH(NCH), .BLK_PER_PKT(BPP), .IVL_STD(256), .IVL_DBL(96)) i_aud_block_framer (
    .clk(clk), .rst(rst), .rate_sel(rate_sel), .in_valid(in_valid), .in_ready(in_ready),
    .in_pcm(in_pcm), .out_valid(out_valid), .out_data(out_data), .out_sop(out_sop),
    .out_eop(out_eop), .out_tag(out_tag));

  always #2 clk = ~clk;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  logic [NCH*24-1:0] q[$];
  int blocks = 0;
  int mk = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic int kind_pos(input int k);
    case (k)
      2, 18:               kind_pos = 1;
      3, 4, 5, 11, 12, 13: kind_pos = 2;
      7, 8, 15, 16:        kind_pos = 3;
      default:             kind_pos = 0;
    endcase
  endfunction

  function automatic int exp_anc(input int k, input int b);
    case (kind_pos(k))
      1:       exp_anc = b % 256;
      2:       exp_anc = (b / 256) % 8;
      3:       exp_anc = ((b / BPP) * BPP) % 256;
      default: exp_anc = 0;
    endcase
  endfunction

  function automatic string anc_req(input int k);
    case (kind_pos(k))
      1: anc_req = "R4";
      2: anc_req = "R5";
      3: anc_req = "R6";
      default: anc_req = "R7";
    endcase
  endfunction

  task automatic monitor();
    if (q.size() > 0) begin
      chk(out_valid == 1'b1, "R2", "out_valid while block pending", out_valid, 1);
      if (out_valid) begin
        logic [NCH*24-1:0] blk;
        logic [23:0] s;
        int k, ivl;
        blk = q[0];
        k = mk + 1;
        s = blk[mk*24 +: 24];
        ivl = rate_sel ? 96 : 256;
        chk(out_data[31:24] == 8'(exp_anc(k, blocks)), anc_req(k),
            $sformatf("anc blk %0d ch %0d", blocks, k), out_data[31:24], exp_anc(k, blocks));
        chk(out_data[23:0] == {s[7:0], s[15:8], s[23:16]}, "R3 R10",
            $sformatf("sample bytes ch %0d", k), out_data[23:0], {s[7:0], s[15:8], s[23:16]});
        chk(out_sop == (k == 1 && blocks % BPP == 0), "R8", "out_sop", out_sop,
            (k == 1 && blocks % BPP == 0));
        chk(out_eop == (k == NCH && blocks % BPP == BPP - 1), "R8", "out_eop", out_eop,
            (k == NCH && blocks % BPP == BPP - 1));
        chk(out_tag == 2'((((blocks / BPP) * BPP) / ivl) % 4), "R9", "out_tag", out_tag,
            (((blocks / BPP) * BPP) / ivl) % 4);
        if (k == NCH)
          chk(in_ready == 1'b1, "R2", "in_ready on last quadlet", in_ready, 1);
        else
          chk(in_ready == 1'b0, "R2", "in_ready while busy", in_ready, 0);
        mk++;
        if (mk == NCH) begin
          mk = 0;
          blocks++;
          void'(q.pop_front());
        end
      end
    end else begin
      chk(out_valid == 1'b0, "R2", "out_valid idle", out_valid, 0);
    end
  endtask

  task automatic do_reset(input logic rate);
    @(negedge clk);
    rst = 1'b1;
    in_valid = 1'b0;
    rate_sel = rate;
    repeat (3) @(negedge clk);
    q.delete();
    blocks = 0;
    mk = 0;
    chk(in_ready == 1'b1, "R1", "in_ready after reset", in_ready, 1);
    chk(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);
    chk(out_tag == 2'd0, "R1", "out_tag after reset", out_tag, 0);
    chk(out_sop == 1'b0 && out_eop == 1'b0, "R1", "markers after reset", {out_sop, out_eop}, 0);
    rst = 1'b0;
  endtask

  task automatic run_phase(input int target, input bit always_on, input bit pattern);
    while (blocks < target) begin
      @(negedge clk);
      monitor();
      if (blocks + q.size() >= target) in_valid = 1'b0;
      else in_valid = always_on ? 1'b1 : (($urandom % 10) < 7);
      for (int c = 0; c < NCH; c++)
        in_pcm[c*24 +: 24] = pattern ? 24'((c + 1) * 24'h010203 + blocks) : 24'($urandom);
      if (in_valid && in_ready) q.push_back(in_pcm);
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    do_reset(1'b0);
    run_phase(40, 1'b1, 1'b1);
    run_phase(2100, 1'b0, 1'b0);
    do_reset(1'b1);
    run_phase(24, 1'b1, 1'b1);
    run_phase(450, 1'b0, 1'b0);
    do_reset(1'b0);
    run_phase(20, 1'b0, 1'b0);
    repeat (4) @(negedge clk);
    monitor();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(4 * 190000);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule